// File: doc/BRIEF.md
# Power-Management Event Controller

This block holds the event logic of a chipset power-management function. A free-running counter advances once per cycle in which `tick_en` is high. The surrounding logic pulses that input at the 3.579545 MHz power-management rate. Software sees four registers on a word-wide register port: the event status, the event enable mask, the control word and the counter. Each time the counter crosses a half-range boundary, the block raises a timer-overflow event. Software acknowledges that event, and the acknowledgement arms detection of the next boundary.

The level interrupt `sci` is high while any status bit that can raise an interrupt is also enabled. The block has three inputs that produce requests. A power-button input either records an event or asks for an immediate shutdown. A write to the control word can carry a suspend request, which becomes a shutdown request or a resume-and-reset request. A byte-wide command port switches the interrupt-mode bit and can raise an SMI pulse.

The counter width is the parameter `CNT_W`, 24 by default. The overflow boundary is always a multiple of 2^(CNT_W-1).

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset the status, enable and control registers and the counter all read 0, and `sci`, `smi_pulse`, `shutdown_req` and `reset_req` are low.
- R2: The counter adds one on each clock edge at which `tick_en` is high and wraps at 2^CNT_W. Register address 3 returns it zero-extended to 32 bits.
- R3: Status bit 0 (timer overflow) is set on the tick that brings the counter to the armed boundary. Out of reset the armed boundary is 2^(CNT_W-1). The bit then stays set, even across counter wrap, until it is cleared as in R4.
- R4: A write to status (address 0) with bit 0 = 1 clears bit 0 if it is set. It also arms the next boundary: the counter value after that edge plus 2^(CNT_W-1), rounded down to a multiple of 2^(CNT_W-1), modulo 2^CNT_W. A write with bit 0 = 0, or with bit 0 = 1 while the bit is clear, changes nothing.
- R5: Status bit 8 (power button) and bit 15 (resume) are cleared by writing 1 and are left unchanged by writing 0. All other status bits read 0.
- R6: The enable register (address 1) stores and returns all 16 written bits. Bit 0 enables the timer event, bit 5 the global event, bit 8 the power button and bit 10 the RTC event.
- R7: `sci` is high exactly when (status AND enable AND 0x0521) is non-zero.
- R8: The control register (address 2) stores every written bit except bit 13, which always reads 0. Bits 12:10 hold the suspend type.
- R9: A control write with bit 13 = 1 and suspend type 0 gives a one-cycle `shutdown_req` in the cycle after the write. With suspend type 1 it sets status bits 15 and 8 and gives a one-cycle `reset_req`. Other types, or bit 13 = 0, give no request.
- R10: A command-port write of 0xF1 sets control bit 0, and 0xF0 clears it. Other values leave the bit unchanged. Every command write gives a one-cycle `smi_pulse` in the cycle after it when `smi_cfg_en` is high, and none when it is low.
- R11: A `pwr_btn` cycle sets status bit 8 when enable bit 8 is 1. When enable bit 8 is 0 it gives a one-cycle `shutdown_req` instead and leaves the status unchanged.
- R12: When two actions hit a bit in the same cycle, setting by an event wins over clearing by a status write, and the command-port update of control bit 0 wins over a control-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 control, 3 counter |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| apm_wr | input | 1 | Command-port write strobe |
| apm_data | input | 8 | Command byte |
| smi_cfg_en | input | 1 | Allows command writes to raise SMI |
| pwr_btn | input | 1 | Power-button event strobe |
| sci | output | 1 | Level system control interrupt |
| smi_pulse | output | 1 | One-cycle SMI request |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that every input strobe is synchronous and lasts one cycle per event. They also assume that the counter moves only under `tick_en`, so a held `pwr_btn` counts as one event per cycle. The bench drives every strobe for exactly one clock, between falling edges. It keeps `tick_en` low during register writes, so the armed boundary can be computed from a known count. It uses a 10-bit counter, so that many clear points and several wraps fit in the run.

// File: rtl/pm_pkg.sv
package pm_pkg;

    // register select codes
    localparam logic [1:0] SEL_STATUS  = 2'd0;
    localparam logic [1:0] SEL_ENABLE  = 2'd1;
    localparam logic [1:0] SEL_CONTROL = 2'd2;
    localparam logic [1:0] SEL_COUNTER = 2'd3;

    // status bit positions
    localparam int ST_TIMER = 0;
    localparam int ST_BUTTON = 8;
    localparam int ST_RESUME = 15;

    // enable bit positions
    localparam int EN_TIMER  = 0;
    localparam int EN_GLOBAL = 5;
    localparam int EN_BUTTON = 8;
    localparam int EN_RTC    = 10;

    // control bit positions
    localparam int CT_IRQMODE = 0;
    localparam int CT_SLEEPGO = 13;
    localparam int CT_TYPE_LO = 10;

    localparam logic [15:0] IRQ_MASK = 16'((1 << EN_TIMER) | (1 << EN_GLOBAL) |
                                           (1 << EN_BUTTON) | (1 << EN_RTC));

    typedef enum logic [2:0] {
        SLP_OFF    = 3'd0,
        SLP_RESUME = 3'd1
    } sleep_kind_e;

    localparam logic [7:0] CMD_IRQ_ON  = 8'hF1;
    localparam logic [7:0] CMD_IRQ_OFF = 8'hF0;

endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ack_req,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);
    localparam int LOW_W = CNT_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             goal_hi;
        logic             flag;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tick_en) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        if (tmr_q.flag) begin
            if (ack_req) begin
                tmr_d.flag    = 1'b0;
                tmr_d.goal_hi = ~tmr_d.cnt[CNT_W-1];
            end
        end else if (tick_en && (tmr_d.cnt == {tmr_q.goal_hi, {LOW_W{1'b0}}})) begin
            tmr_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt     <= '0;
            tmr_q.goal_hi <= 1'b1;
            tmr_q.flag    <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign count    = tmr_q.cnt;
    assign ovf_flag = tmr_q.flag;

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic        apm_wr,
    input  logic [7:0]  apm_data,
    input  logic        smi_cfg_en,
    input  logic        pwr_btn,
    output logic        button_flag,
    output logic        resume_flag,
    output logic [15:0] enable,
    output logic [15:0] control,
    output logic        shutdown_req,
    output logic        reset_req,
    output logic        smi_pulse
);
    typedef struct packed {
        logic        btn;
        logic        rsm;
        logic [15:0] en;
        logic [15:0] ctl;
        logic        shut;
        logic        rst;
        logic        smi;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_sts, wr_en, wr_ctl;
    logic [2:0] kind;

    assign wr_sts = reg_wr && (reg_addr == SEL_STATUS);
    assign wr_en  = reg_wr && (reg_addr == SEL_ENABLE);
    assign wr_ctl = reg_wr && (reg_addr == SEL_CONTROL);
    assign kind   = reg_wdata[CT_TYPE_LO +: 3];

    always_comb begin
        regs_d      = regs_q;
        regs_d.shut = 1'b0;
        regs_d.rst  = 1'b0;
        regs_d.smi  = 1'b0;

        // acknowledge first so that events below take priority
        if (wr_sts) begin
            if (reg_wdata[ST_BUTTON]) regs_d.btn = 1'b0;
            if (reg_wdata[ST_RESUME]) regs_d.rsm = 1'b0;
        end

        if (wr_en) begin
            regs_d.en = reg_wdata;
        end

        if (wr_ctl) begin
            regs_d.ctl = reg_wdata & ~(16'd1 << CT_SLEEPGO);
            if (reg_wdata[CT_SLEEPGO]) begin
                case (kind)
                    SLP_OFF: regs_d.shut = 1'b1;
                    SLP_RESUME: begin
                        regs_d.rsm = 1'b1;
                        regs_d.btn = 1'b1;
                        regs_d.rst = 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        if (pwr_btn) begin
            if (regs_q.en[EN_BUTTON]) regs_d.btn  = 1'b1;
            else                      regs_d.shut = 1'b1;
        end

        if (apm_wr) begin
            if (apm_data == CMD_IRQ_ON)       regs_d.ctl[CT_IRQMODE] = 1'b1;
            else if (apm_data == CMD_IRQ_OFF) regs_d.ctl[CT_IRQMODE] = 1'b0;
            if (smi_cfg_en) regs_d.smi = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign button_flag  = regs_q.btn;
    assign resume_flag  = regs_q.rsm;
    assign enable       = regs_q.en;
    assign control      = regs_q.ctl;
    assign shutdown_req = regs_q.shut;
    assign reset_req    = regs_q.rst;
    assign smi_pulse    = regs_q.smi;

endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
    import pm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        apm_wr,
    input  logic [7:0]  apm_data,
    input  logic        smi_cfg_en,
    input  logic        pwr_btn,
    output logic        sci,
    output logic        smi_pulse,
    output logic        shutdown_req,
    output logic        reset_req
);
    logic [CNT_W-1:0] tmr_cnt;
    logic             ovf_flag;
    logic             button_flag;
    logic             resume_flag;
    logic [15:0]      en_w;
    logic [15:0]      ctl_w;
    logic [15:0]      sts_w;
    logic             ack_tmr;

    assign ack_tmr = reg_wr && (reg_addr == SEL_STATUS) && reg_wdata[ST_TIMER];

    pm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .ack_req  (ack_tmr),
        .count    (tmr_cnt),
        .ovf_flag (ovf_flag)
    );

    pm_evt_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .apm_wr       (apm_wr),
        .apm_data     (apm_data),
        .smi_cfg_en   (smi_cfg_en),
        .pwr_btn      (pwr_btn),
        .button_flag  (button_flag),
        .resume_flag  (resume_flag),
        .enable       (en_w),
        .control      (ctl_w),
        .shutdown_req (shutdown_req),
        .reset_req    (reset_req),
        .smi_pulse    (smi_pulse)
    );

    always_comb begin
        sts_w            = '0;
        sts_w[ST_TIMER]  = ovf_flag;
        sts_w[ST_BUTTON] = button_flag;
        sts_w[ST_RESUME] = resume_flag;
    end

    assign sci = |(sts_w & en_w & IRQ_MASK);

    always_comb begin
        case (reg_addr)
            SEL_STATUS:  reg_rdata = {16'd0, sts_w};
            SEL_ENABLE:  reg_rdata = {16'd0, en_w};
            SEL_CONTROL: reg_rdata = {16'd0, ctl_w};
            default:     reg_rdata = 32'(tmr_cnt);
        endcase
    end

endmodule

// File: rtl/pm_event_ctrl_chk.sv
module pm_event_ctrl_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [15:0]      reg_wdata,
    input logic             apm_wr,
    input logic [7:0]       apm_data,
    input logic             smi_cfg_en,
    input logic             pwr_btn,
    input logic [CNT_W-1:0] cnt,
    input logic [15:0]      sts,
    input logic [15:0]      en,
    input logic [15:0]      ctl,
    input logic             sci,
    input logic             smi
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt)); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sts[0] && !(reg_wr && reg_addr == 2'd0 && reg_wdata[0]) |=> sts[0]); // R3
    AST_SLEEPGO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !ctl[13]); // R8
    AST_CMD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        apm_wr && apm_data == 8'hF1 |=> ctl[0]); // R10
    AST_SMI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> $past(apm_wr && smi_cfg_en)); // R10
    AST_BUTTON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_btn && en[8] |=> sci && sts[8]); // R11
endmodule

bind pm_event_ctrl pm_event_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .apm_wr     (apm_wr),
    .apm_data   (apm_data),
    .smi_cfg_en (smi_cfg_en),
    .pwr_btn    (pwr_btn),
    .cnt        (tmr_cnt),
    .sts        (sts_w),
    .en         (en_w),
    .ctl        (ctl_w),
    .sci        (sci),
    .smi        (smi_pulse)
);

// File: tb/pm_event_ctrl_bench.sv
module pm_event_ctrl_bench;
    localparam int CW   = 10;
    localparam int HALF = 1 << (CW - 1);
    localparam int FULL = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [31:0] reg_rdata;
    logic        apm_wr = 1'b0;
    logic [7:0]  apm_data = 8'd0;
    logic        smi_cfg_en = 1'b0;
    logic        pwr_btn = 1'b0;
    logic        sci, smi_pulse, shutdown_req, reset_req;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    pm_event_ctrl #(.CNT_W(CW)) u_pm_event_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .apm_wr(apm_wr), .apm_data(apm_data),
        .smi_cfg_en(smi_cfg_en), .pwr_btn(pwr_btn), .sci(sci),
        .smi_pulse(smi_pulse), .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete act=hung exp=done");
        report();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] d);
        apm_wr = 1'b1; apm_data = d;
        @(negedge clk);
        apm_wr = 1'b0;
    endtask

    task automatic button();
        pwr_btn = 1'b1;
        @(negedge clk);
        pwr_btn = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
            exp_cnt = (exp_cnt + n) % FULL;
        end
    endtask

    initial begin
        logic [31:0] v;
        logic        ctl0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg after reset", v, 32'd0);
        end
        chk("R1 outputs after reset", {28'd0, sci, smi_pulse, shutdown_req, reset_req}, 32'd0);

        // R3 first boundary from reset
        ticks(HALF - 1);
        rd(2'd0, v); chk("R3 before first boundary", v & 32'h1, 32'd0);
        ticks(1);
        rd(2'd0, v); chk("R3 at first boundary", v & 32'h1, 32'd1);
        rd(2'd3, v); chk("R2 count at boundary", v, 32'(exp_cnt));

        // R2/R3/R4 sweep over many clear points
        for (int i = 0; i < 24; i++) begin
            int adv;
            int tgt;
            int k;
            adv = (i * 73 + 5) % 300;
            ticks(adv);
            rd(2'd3, v); chk("R2 count value", v, 32'(exp_cnt));
            rd(2'd0, v); chk("R3 flag stays set", v & 32'h1, 32'd1);
            wr(2'd0, 16'h0000);
            rd(2'd0, v); chk("R4 zero write keeps flag", v & 32'h1, 32'd1);
            wr(2'd0, 16'h0001);
            rd(2'd0, v); chk("R4 ack clears flag", v & 32'h1, 32'd0);
            tgt = ((exp_cnt + HALF) / HALF * HALF) % FULL;
            k = (tgt - exp_cnt + FULL) % FULL;
            if (k == 0) k = FULL;
            ticks(k - 1);
            rd(2'd0, v); chk("R4 not set before armed boundary", v & 32'h1, 32'd0);
            if (i % 4 == 0) begin
                wr(2'd0, 16'h0001);
                rd(2'd0, v); chk("R4 ack while clear has no effect", v & 32'h1, 32'd0);
            end
            ticks(1);
            rd(2'd0, v); chk("R4 set at armed boundary", v & 32'h1, 32'd1);
        end

        // R6/R7 enable readback and interrupt per bit (timer flag set, others clear)
        for (int b = 0; b < 16; b++) begin
            wr(2'd1, 16'(1 << b));
            rd(2'd1, v); chk("R6 enable readback", v, 32'(1 << b));
            chk("R7 sci per enable bit", {31'd0, sci}, {31'd0, b == 0});
        end
        wr(2'd1, 16'hFFFE);
        chk("R7 sci with no matching event", {31'd0, sci}, 32'd0);

        // R11 button with enable clear -> shutdown, status unchanged
        wr(2'd1, 16'h0000);
        button();
        chk("R11 shutdown pulse", {31'd0, shutdown_req}, 32'd1);
        @(negedge clk);
        chk("R11 shutdown pulse one cycle", {31'd0, shutdown_req}, 32'd0);
        rd(2'd0, v); chk("R11 status unchanged", v & 32'h0100, 32'd0);

        // R11/R5 button with enable set
        wr(2'd1, 16'h0100);
        button();
        chk("R11 no shutdown when enabled", {31'd0, shutdown_req}, 32'd0);
        rd(2'd0, v); chk("R11 button status", v & 32'h0100, 32'h0100);
        chk("R7 sci from button", {31'd0, sci}, 32'd1);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); chk("R5 zero write keeps button", v & 32'h0100, 32'h0100);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); chk("R5 all-ones write clears all", v, 32'd0);
        chk("R7 sci low after clear", {31'd0, sci}, 32'd0);

        // R12 button set wins over same-cycle clear
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0100; pwr_btn = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; pwr_btn = 1'b0;
        rd(2'd0, v); chk("R12 set beats clear", v & 32'h0100, 32'h0100);
        wr(2'd0, 16'h0100);

        // R8 control storage, bit 13 never stored
        for (int b = 0; b < 16; b++) begin
            if (b != 13) begin
                wr(2'd2, 16'(1 << b));
                rd(2'd2, v); chk("R8 control readback", v, 32'(1 << b));
            end
        end
        wr(2'd2, 16'h1C00);
        chk("R9 no request without go bit", {30'd0, shutdown_req, reset_req}, 32'd0);

        // R9 all suspend types with go bit
        for (int t = 0; t < 8; t++) begin
            wr(2'd2, 16'(16'h2000 | (t << 10) | 16'h0002));
            chk("R9 shutdown by type", {31'd0, shutdown_req}, {31'd0, t == 0});
            chk("R9 reset by type", {31'd0, reset_req}, {31'd0, t == 1});
            rd(2'd2, v); chk("R8 go bit reads zero", v, 32'((t << 10) | 2));
            rd(2'd0, v); chk("R9 resume status", v, (t == 1) ? 32'h8100 : 32'h0);
            @(negedge clk);
            chk("R9 pulses one cycle", {30'd0, shutdown_req, reset_req}, 32'd0);
            wr(2'd0, 16'h8100);
        end

        // R10 command port sweep
        wr(2'd2, 16'h0000);
        ctl0 = 1'b0;
        for (int c = 0; c < 2; c++) begin
            logic [7:0] seq [6];
            seq[0] = 8'hF1; seq[1] = 8'h00; seq[2] = 8'hF0;
            seq[3] = 8'hFF; seq[4] = 8'hF1; seq[5] = 8'hF2;
            smi_cfg_en = (c == 1);
            for (int j = 0; j < 6; j++) begin
                cmd(seq[j]);
                if (seq[j] == 8'hF1) ctl0 = 1'b1;
                else if (seq[j] == 8'hF0) ctl0 = 1'b0;
                chk("R10 smi gating", {31'd0, smi_pulse}, {31'd0, c == 1});
                rd(2'd2, v); chk("R10 mode bit", v, {31'd0, ctl0});
                @(negedge clk);
                chk("R10 smi one cycle", {31'd0, smi_pulse}, 32'd0);
            end
        end

        // R12 command beats control write on bit 0
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0000;
        apm_wr = 1'b1; apm_data = 8'hF1;
        @(negedge clk);
        reg_wr = 1'b0; apm_wr = 1'b0;
        rd(2'd2, v); chk("R12 command wins bit 0", v, 32'd1);

        report();
    end
endmodule